// File: doc/BRIEF.md
# Sector Buffer Manager Sequencer

This block walks a buffered transfer through the sectors of a disk track that is split into two blocks. Each block carries 85 data sectors. In read mode these are followed by 4 check (C2) sectors and then one gap sector. A control-word write selects the starting block, arms block chaining and starts the sequencer. After that, each buffer-service event advances it by one sector. A buffer-service event is the host moving a sector into or out of the data buffer. The block raises a data-request flag, a C2-transfer flag and a buffer interrupt for the host, and gives strobes that mark when a sector is loaded (read) or committed (write). Media storage and error correction live elsewhere.

The control logic has three states. ST_IDLE is stopped. ST_RUN is stepping. ST_HOLD is held in manager reset. These transitions exist:
- ST_IDLE goes to ST_RUN on a start write.
- ST_RUN goes to ST_IDLE when the gap sector (read) or the last write sector completes without chaining.
- Any state goes to ST_HOLD on a write with the hold bit set.
- ST_HOLD goes to ST_IDLE on a write with the hold bit clear, which also clears the flags. If that write also carries the start bit, the state goes straight to ST_RUN.

A step in read mode on the quirk track (track 6) with block 0 selected fails. The sequencer withholds the data request and sets a micro-error flag instead of moving.

Top module: `sector_seq`

## Requirements
- R1: After reset all flags are 0, sector is 0, block is 0, and running, rd_stb and wr_stb are 0.
- R2: On a ctl_word write, bits 23:16 equal to 0x00 select block 0 and 0x5A select block 1, and either one sets sector to 0. Any other value sets align_err and leaves sector and block unchanged.
- R3: On a ctl_word write, bit 25 sets chain. Bit 31 (with bit 28 clear) sets running and performs one step in the same cycle.
- R4: A ctl_word write with bit 28 set enters hold. Hold clears running, and advances are ignored while held. The next write with bit 28 clear clears data_req, c2_xfer, bm_int, align_err, micro_err, chain and running, and sets sector and block to 0.
- R5: A read step at sector 0..84 pulses rd_stb, increments sector, and sets data_req and bm_int.
- R6: A read step at sector 85..88 increments sector and sets bm_int without setting data_req. c2_xfer is set when sector becomes 89.
- R7: A read step at sector 89 with chain set toggles block, sets sector to 0, clears chain and keeps running. Without chain it clears running. Both cases set bm_int.
- R8: A write step at sector 0 sets sector to 1 and sets data_req without wr_stb. A write step at sector 1..84 pulses wr_stb, increments sector and sets data_req. Every write step sets bm_int.
- R9: A write step at sector 85 pulses wr_stb. With chain set it toggles block, sets sector to 1, clears chain and sets data_req. Without chain it sets sector to 86 and clears running.
- R10: A read step with track equal to 6 and block 0 leaves sector unchanged, clears data_req, sets micro_err and does not set bm_int.
- R11: data_svc clears data_req and bm_int. c2_svc clears c2_xfer and bm_int. A step in the same cycle sets its flags after these clears.
- R12: stat_rd while bm_int is set and sector is above 85 clears bm_int and, when running, performs one step.
- R13: adv has no effect on sector, block or the strobes while running is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 32 | Control word (select bits 23:16, chain 25, hold 28, start 31) |
| adv | input | 1 | Buffer-service advance pulse |
| data_svc | input | 1 | Host serviced the data buffer |
| c2_svc | input | 1 | Host serviced the C2 buffer |
| stat_rd | input | 1 | Host read of the status word |
| wr_mode | input | 1 | 1 = write transfer, 0 = read transfer |
| track | input | 12 | Current track number |
| running | output | 1 | Sequencer running |
| chain | output | 1 | Chain to other block pending |
| data_req | output | 1 | Data request flag |
| c2_xfer | output | 1 | C2 transfer flag |
| bm_int | output | 1 | Buffer manager interrupt |
| micro_err | output | 1 | Read failure on the quirk track |
| align_err | output | 1 | Misaligned start select |
| sector | output | 7 | Current sector counter |
| block | output | 1 | Selected block |
| rd_stb | output | 1 | Sector load strobe; loaded sector is sector-1 |
| wr_stb | output | 1 | Sector commit strobe |

## Verification
The bench targets these corner cases:
- The read gap sector both with and without chaining. A design that got the gap wrong would stop early or fail to flip the block.
- The write-mode last sector. Here the counter must restart at 1 rather than 0. An off-by-one would commit a phantom sector or skip a data request.
- A service pulse and a step landing in the same cycle. If a clear overrode the step's set, the request would be lost.
- A status read past sector 85 while the sequencer is stopped. A design that stepped anyway would move a stopped sequencer.
- The quirk-track stall, and hold/release while a run is in progress.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic sel_ok;
        logic sel_blk;
        logic chain_set;
        logic hold;
        logic start;
    } ctl_fields_t;

endpackage

// File: rtl/sector_seq_ctl_dec.sv
module sector_seq_ctl_dec
    import sector_seq_pkg::*;
#(
    parameter int          CTL_W     = 32,
    parameter int          SEL_LSB   = 16,
    parameter int          CHAIN_BIT = 25,
    parameter int          HOLD_BIT  = 28,
    parameter int          GO_BIT    = 31,
    parameter logic [7:0]  BLK1_CODE = 8'h5A
) (
    input  logic [CTL_W-1:0] word,
    output ctl_fields_t      fields
);
    logic [7:0] sel;
    logic       unused_word;

    assign unused_word = ^word;

    always_comb begin
        sel              = word[SEL_LSB +: 8];
        fields.sel_ok    = (sel == 8'h00) || (sel == BLK1_CODE);
        fields.sel_blk   = (sel == BLK1_CODE);
        fields.chain_set = word[CHAIN_BIT];
        fields.hold      = word[HOLD_BIT];
        fields.start     = word[GO_BIT];
    end
endmodule

// File: rtl/sector_seq_quirk.sv
module sector_seq_quirk #(
    parameter int TRACK_W     = 12,
    parameter int QUIRK_TRACK = 6
) (
    input  logic [TRACK_W-1:0] track,
    input  logic               blk,
    input  logic               wr_mode,
    output logic               fail
);
    localparam logic [TRACK_W-1:0] QT = TRACK_W'(QUIRK_TRACK);

    assign fail = !wr_mode && (track == QT) && !blk;
endmodule

// File: rtl/sector_seq_step.sv
module sector_seq_step #(
    parameter int DATA_SECTORS = 85,
    parameter int C2_SECTORS   = 4,
    parameter int CNT_W        = 7
) (
    input  logic             do_step,
    input  logic             wr_mode,
    input  logic             fail,
    input  logic [CNT_W-1:0] sec,
    input  logic             blk,
    input  logic             chain_in,
    output logic [CNT_W-1:0] n_sec,
    output logic             n_blk,
    output logic             n_chain,
    output logic             set_dreq,
    output logic             clr_dreq,
    output logic             set_c2,
    output logic             set_int,
    output logic             stop,
    output logic             set_micro,
    output logic             rd_pulse,
    output logic             wr_pulse
);
    localparam int               GAP       = DATA_SECTORS + C2_SECTORS;
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_SECTORS);
    localparam logic [CNT_W-1:0] GAP_C     = CNT_W'(GAP);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    always_comb begin
        n_sec     = sec;
        n_blk     = blk;
        n_chain   = chain_in;
        set_dreq  = 1'b0;
        clr_dreq  = 1'b0;
        set_c2    = 1'b0;
        set_int   = 1'b0;
        stop      = 1'b0;
        set_micro = 1'b0;
        rd_pulse  = 1'b0;
        wr_pulse  = 1'b0;
        if (do_step) begin
            if (wr_mode) begin
                set_int = 1'b1;
                if (sec == '0) begin
                    n_sec    = ONE;
                    set_dreq = 1'b1;
                end else if (sec < LAST_DATA) begin
                    wr_pulse = 1'b1;
                    n_sec    = sec + ONE;
                    set_dreq = 1'b1;
                end else if (sec == LAST_DATA) begin
                    wr_pulse = 1'b1;
                    if (chain_in) begin
                        n_blk    = !blk;
                        n_sec    = ONE;
                        n_chain  = 1'b0;
                        set_dreq = 1'b1;
                    end else begin
                        n_sec = sec + ONE;
                        stop  = 1'b1;
                    end
                end
            end else if (fail) begin
                clr_dreq  = 1'b1;
                set_micro = 1'b1;
            end else begin
                set_int = 1'b1;
                if (sec < LAST_DATA) begin
                    rd_pulse = 1'b1;
                    n_sec    = sec + ONE;
                    set_dreq = 1'b1;
                end else if (sec < GAP_C) begin
                    n_sec  = sec + ONE;
                    set_c2 = ((sec + ONE) == GAP_C);
                end else if (chain_in) begin
                    n_blk   = !blk;
                    n_sec   = '0;
                    n_chain = 1'b0;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sector_seq.sv
module sector_seq
    import sector_seq_pkg::*;
#(
    parameter int  DATA_SECTORS = 85,
    parameter int  C2_SECTORS   = 4,
    parameter int  TRACK_W      = 12,
    parameter int  QUIRK_TRACK  = 6,
    parameter int  CTL_W        = 32,
    localparam int GAP          = DATA_SECTORS + C2_SECTORS,
    localparam int CNT_W        = $clog2(GAP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_word,
    input  logic               adv,
    input  logic               data_svc,
    input  logic               c2_svc,
    input  logic               stat_rd,
    input  logic               wr_mode,
    input  logic [TRACK_W-1:0] track,
    output logic               running,
    output logic               chain,
    output logic               data_req,
    output logic               c2_xfer,
    output logic               bm_int,
    output logic               micro_err,
    output logic               align_err,
    output logic [CNT_W-1:0]   sector,
    output logic               block,
    output logic               rd_stb,
    output logic               wr_stb
);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_SECTORS);

    seq_state_t       state_q, p_state, n_state;
    logic [CNT_W-1:0] sec_q, p_sec, s_sec;
    logic             blk_q, p_blk, s_blk;
    logic             chain_q, p_chain, s_chain;
    logic             dreq_q, p_dreq, n_dreq;
    logic             c2_q, p_c2;
    logic             int_q, p_int;
    logic             micro_q, p_micro;
    logic             aerr_q, p_aerr;
    logic             rd_q, wr_q;
    logic             stat_hit, go, do_step, quirk_fail;
    logic             s_set_dreq, s_clr_dreq, s_set_c2, s_set_int;
    logic             s_stop, s_set_micro, s_rd, s_wr;
    ctl_fields_t      cf;

    sector_seq_ctl_dec #(.CTL_W(CTL_W)) u_dec (
        .word   (ctl_word),
        .fields (cf)
    );

    sector_seq_quirk #(.TRACK_W(TRACK_W), .QUIRK_TRACK(QUIRK_TRACK)) u_quirk (
        .track   (track),
        .blk     (p_blk),
        .wr_mode (wr_mode),
        .fail    (quirk_fail)
    );

    sector_seq_step #(
        .DATA_SECTORS (DATA_SECTORS),
        .C2_SECTORS   (C2_SECTORS),
        .CNT_W        (CNT_W)
    ) u_step (
        .do_step   (do_step),
        .wr_mode   (wr_mode),
        .fail      (quirk_fail),
        .sec       (p_sec),
        .blk       (p_blk),
        .chain_in  (p_chain),
        .n_sec     (s_sec),
        .n_blk     (s_blk),
        .n_chain   (s_chain),
        .set_dreq  (s_set_dreq),
        .clr_dreq  (s_clr_dreq),
        .set_c2    (s_set_c2),
        .set_int   (s_set_int),
        .stop      (s_stop),
        .set_micro (s_set_micro),
        .rd_pulse  (s_rd),
        .wr_pulse  (s_wr)
    );

    // Host clears and control-word effects, ahead of the sector step.
    always_comb begin : pre_step
        p_state  = state_q;
        p_sec    = sec_q;
        p_blk    = blk_q;
        p_chain  = chain_q;
        p_dreq   = dreq_q;
        p_c2     = c2_q;
        p_int    = int_q;
        p_micro  = micro_q;
        p_aerr   = aerr_q;
        go       = 1'b0;
        stat_hit = stat_rd && int_q && (sec_q > LAST_DATA);
        if (data_svc) begin
            p_dreq = 1'b0;
            p_int  = 1'b0;
        end
        if (c2_svc) begin
            p_c2  = 1'b0;
            p_int = 1'b0;
        end
        if (stat_hit) p_int = 1'b0;
        if (ctl_wr) begin
            if (cf.sel_ok) begin
                p_blk = cf.sel_blk;
                p_sec = '0;
            end else begin
                p_aerr = 1'b1;
            end
            if (cf.chain_set) p_chain = 1'b1;
            if (cf.hold) begin
                p_state = ST_HOLD;
            end else begin
                if (state_q == ST_HOLD) begin
                    p_dreq  = 1'b0;
                    p_c2    = 1'b0;
                    p_int   = 1'b0;
                    p_aerr  = 1'b0;
                    p_micro = 1'b0;
                    p_chain = 1'b0;
                    p_sec   = '0;
                    p_blk   = 1'b0;
                    p_state = ST_IDLE;
                end
                if (cf.start) begin
                    p_state = ST_RUN;
                    go      = 1'b1;
                end
            end
        end
        do_step = go || ((adv || stat_hit) && (state_q == ST_RUN) && (p_state == ST_RUN));
    end

    always_comb begin : post_step
        n_state = p_state;
        n_dreq  = p_dreq;
        if (s_clr_dreq) n_dreq = 1'b0;
        if (s_set_dreq) n_dreq = 1'b1;
        if (s_stop)     n_state = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sec_q   <= '0;
            blk_q   <= 1'b0;
            chain_q <= 1'b0;
            dreq_q  <= 1'b0;
            c2_q    <= 1'b0;
            int_q   <= 1'b0;
            micro_q <= 1'b0;
            aerr_q  <= 1'b0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= n_state;
            sec_q   <= s_sec;
            blk_q   <= s_blk;
            chain_q <= s_chain;
            dreq_q  <= n_dreq;
            c2_q    <= p_c2 | s_set_c2;
            int_q   <= p_int | s_set_int;
            micro_q <= p_micro | s_set_micro;
            aerr_q  <= p_aerr;
            rd_q    <= s_rd;
            wr_q    <= s_wr;
        end
    end

    always_comb begin : out_dec
        unique case (state_q)
            ST_RUN:           running = 1'b1;
            ST_IDLE, ST_HOLD: running = 1'b0;
            default:          running = 1'b0;
        endcase
        chain     = chain_q;
        data_req  = dreq_q;
        c2_xfer   = c2_q;
        bm_int    = int_q;
        micro_err = micro_q;
        align_err = aerr_q;
        sector    = sec_q;
        block     = blk_q;
        rd_stb    = rd_q;
        wr_stb    = wr_q;
    end
endmodule

// File: rtl/sector_seq_chk.sv
module sector_seq_chk #(
    parameter int GAP_C = 89,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             wr_mode,
    input logic             running,
    input logic             data_req,
    input logic             c2_xfer,
    input logic             micro_err,
    input logic [CNT_W-1:0] sector,
    input logic             rd_stb,
    input logic             wr_stb
);
    AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sector <= CNT_W'(GAP_C)); // R6
    AST_LOAD_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> data_req); // R5
    AST_COMMIT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(wr_mode)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R8
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctl_wr) |=> ($stable(sector) && !rd_stb && !wr_stb)); // R13
    AST_C2_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c2_xfer) |-> (sector == CNT_W'(GAP_C))); // R6
    AST_QUIRK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(micro_err) && !$past(ctl_wr)) |-> $stable(sector)); // R10
endmodule

bind sector_seq sector_seq_chk #(.GAP_C(GAP), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .wr_mode   (wr_mode),
    .running   (running),
    .data_req  (data_req),
    .c2_xfer   (c2_xfer),
    .micro_err (micro_err),
    .sector    (sector),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb)
);

// File: tb/sector_seq_test.sv
module sector_seq_test;
    localparam int DS  = 85;
    localparam int GAP = 89;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_ctl_wr = 1'b0;
    logic [31:0] i_ctl = '0;
    logic        i_adv = 1'b0, i_dsvc = 1'b0, i_csvc = 1'b0, i_srd = 1'b0;
    logic        i_wr_mode = 1'b0;
    logic [11:0] i_track = 12'd100;

    logic       running, chain, data_req, c2_xfer, bm_int, micro_err, align_err;
    logic [6:0] sector;
    logic       block, rd_stb, wr_stb;

    always #2 clk = ~clk;

    sector_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(i_ctl_wr), .ctl_word(i_ctl),
        .adv(i_adv), .data_svc(i_dsvc), .c2_svc(i_csvc), .stat_rd(i_srd),
        .wr_mode(i_wr_mode), .track(i_track),
        .running(running), .chain(chain), .data_req(data_req), .c2_xfer(c2_xfer),
        .bm_int(bm_int), .micro_err(micro_err), .align_err(align_err),
        .sector(sector), .block(block), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state: 0 idle, 1 running, 2 held
    int m_state = 0, m_sec = 0;
    bit m_blk, m_chain, m_dreq, m_c2, m_int, m_micro, m_aerr, m_rd, m_wr;

    task automatic chk(string tag, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(bit go, bit hold, bit chn, logic [7:0] sel);
        return {go, 2'b00, hold, 1'b0, 1'b0, chn, 1'b0, sel, 16'h0000};
    endfunction

    task automatic model_cycle();
        bit hit, go, step;
        int st;
        logic [7:0] sel;
        m_rd = 0;
        m_wr = 0;
        hit = i_srd && m_int && (m_sec > DS);
        if (i_dsvc) begin m_dreq = 0; m_int = 0; end
        if (i_csvc) begin m_c2 = 0; m_int = 0; end
        if (hit) m_int = 0;
        st = m_state;
        go = 0;
        if (i_ctl_wr) begin
            sel = i_ctl[23:16];
            if (sel == 8'h00 || sel == 8'h5A) begin m_blk = (sel == 8'h5A); m_sec = 0; end
            else m_aerr = 1;
            if (i_ctl[25]) m_chain = 1;
            if (i_ctl[28]) st = 2;
            else begin
                if (m_state == 2) begin
                    m_dreq = 0; m_c2 = 0; m_int = 0; m_aerr = 0; m_micro = 0;
                    m_chain = 0; m_sec = 0; m_blk = 0; st = 0;
                end
                if (i_ctl[31]) begin st = 1; go = 1; end
            end
        end
        step = go || ((i_adv || hit) && m_state == 1 && st == 1);
        m_state = st;
        if (step) begin
            if (i_wr_mode) begin
                m_int = 1;
                if (m_sec == 0) begin m_sec = 1; m_dreq = 1; end
                else if (m_sec < DS) begin m_wr = 1; m_sec++; m_dreq = 1; end
                else if (m_sec == DS) begin
                    m_wr = 1;
                    if (m_chain) begin m_blk = !m_blk; m_sec = 1; m_chain = 0; m_dreq = 1; end
                    else begin m_sec++; m_state = 0; end
                end
            end else if (i_track == 12'd6 && !m_blk) begin
                m_dreq = 0; m_micro = 1;
            end else begin
                m_int = 1;
                if (m_sec < DS) begin m_rd = 1; m_sec++; m_dreq = 1; end
                else if (m_sec < GAP) begin m_sec++; if (m_sec == GAP) m_c2 = 1; end
                else if (m_chain) begin m_blk = !m_blk; m_sec = 0; m_chain = 0; end
                else m_state = 0;
            end
        end
    endtask

    task automatic compare_all();
        chk("R3",  "running",   running,   m_state == 1);
        chk("R3",  "chain",     chain,     m_chain);
        chk("R5",  "data_req",  data_req,  m_dreq);
        chk("R6",  "c2_xfer",   c2_xfer,   m_c2);
        chk("R11", "bm_int",    bm_int,    m_int);
        chk("R10", "micro_err", micro_err, m_micro);
        chk("R2",  "align_err", align_err, m_aerr);
        chk("R5",  "sector",    sector,    m_sec);
        chk("R7",  "block",     block,     m_blk);
        chk("R5",  "rd_stb",    rd_stb,    m_rd);
        chk("R8",  "wr_stb",    wr_stb,    m_wr);
    endtask

    task automatic cyc(bit c, logic [31:0] w, bit a, bit ds, bit cs, bit sr);
        i_ctl_wr = c; i_ctl = w; i_adv = a; i_dsvc = ds; i_csvc = cs; i_srd = sr;
        model_cycle();
        @(posedge clk);
        @(negedge clk);
        i_ctl_wr = 0; i_adv = 0; i_dsvc = 0; i_csvc = 0; i_srd = 0;
        compare_all();
    endtask

    task automatic advn(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "sector", sector, 0);
        chk("R1", "block", block, 0);
        chk("R1", "running", running, 0);
        chk("R1", "flags", {data_req, c2_xfer, bm_int, micro_err, align_err, chain}, 0);
        chk("R1", "strobes", {rd_stb, wr_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // Read run, chaining at the gap
        cyc(1, cw(1, 0, 1, 8'h00), 0, 0, 0, 0);
        chk("R3", "start steps at once", sector, 1);
        chk("R5", "first load strobe", rd_stb, 1);
        advn(84);
        chk("R5", "last data sector", sector, 85);
        advn(4);
        chk("R6", "c2 at 89", c2_xfer, 1);
        chk("R6", "sector 89", sector, 89);
        advn(1);
        chk("R7", "chained block", block, 1);
        chk("R7", "chained sector", sector, 0);
        chk("R7", "still running", running, 1);
        advn(89);
        advn(1);
        chk("R7", "stop at gap", running, 0);
        advn(1);
        chk("R13", "idle adv", sector, 89);

        // Write run from block 1 with chain
        i_wr_mode = 1'b1;
        cyc(1, cw(1, 0, 1, 8'h5A), 0, 0, 0, 0);
        chk("R8", "first write no commit", wr_stb, 0);
        chk("R8", "first write sector", sector, 1);
        advn(84);
        chk("R8", "write sector 85", sector, 85);
        advn(1);
        chk("R9", "write chain block", block, 0);
        chk("R9", "write chain sector", sector, 1);
        chk("R9", "write chain commit", wr_stb, 1);
        advn(84);
        advn(1);
        chk("R9", "write stop sector", sector, 86);
        chk("R9", "write stop", running, 0);

        // Hold and release
        i_wr_mode = 1'b0;
        cyc(1, cw(0, 1, 0, 8'h00), 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R4", "held ignores adv", running, 0);
        cyc(1, cw(0, 0, 0, 8'h00), 0, 0, 0, 0);
        chk("R4", "release flags", {data_req, c2_xfer, bm_int, micro_err, align_err, chain}, 0);

        // Status read past sector 85
        cyc(1, cw(1, 0, 0, 8'h00), 0, 0, 0, 0);
        advn(85);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R12", "status read step", sector, 87);
        advn(2);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R11", "c2 svc", {c2_xfer, bm_int}, 0);
        advn(1);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R11", "data svc", {data_req, bm_int}, 0);

        // Quirk track
        cyc(1, cw(0, 1, 0, 8'h00), 0, 0, 0, 0);
        cyc(1, cw(0, 0, 0, 8'h00), 0, 0, 0, 0);
        i_track = 12'd6;
        cyc(1, cw(1, 0, 0, 8'h00), 0, 0, 0, 0);
        chk("R10", "quirk stall", {micro_err, data_req, bm_int}, 3'b100);
        chk("R10", "quirk sector", sector, 0);
        i_track = 12'd100;

        // Start select field
        cyc(1, cw(0, 0, 0, 8'h33), 0, 0, 0, 0);
        chk("R2", "misaligned", align_err, 1);
        cyc(1, cw(0, 0, 0, 8'h5A), 0, 0, 0, 0);
        chk("R2", "select block 1", block, 1);

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [7:0] sel;
            r = $urandom % 100;
            if ($urandom % 50 == 0) i_wr_mode = ~i_wr_mode;
            if ($urandom % 20 == 0) i_track = ($urandom % 3 == 0) ? 12'd6 : 12'($urandom);
            sel = ($urandom % 8 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h5A : 8'h00);
            if (r < 6)
                cyc(1, cw(($urandom % 2) == 1, ($urandom % 8) == 0, ($urandom % 2) == 1, sel),
                    ($urandom % 2) == 1, ($urandom % 6) == 0, ($urandom % 6) == 0, 0);
            else
                cyc(0, 0, r < 60, ($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 6) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule